// File: doc/BRIEF.md
# Register Scoreboard Hazard Interlock

This block guards the decode stage of a single-issue processor. The processor has a 32-entry register file and two execution pipelines of unequal depth: an integer pipeline that returns a result three clocks after issue, and a floating-point pipeline that returns one five clocks after issue. For every register the block keeps a single stale flag. The flag is raised when an instruction naming that register as its destination leaves decode. It drops when the pipeline producing that value reports completion.

In each cycle the decoded instruction presents two source indices, a destination index, a write flag and a pipeline selector. The block holds the instruction back if either source is stale, or if its destination still waits on an older result. When the block holds an instruction, fetch stays frozen and the execute stage receives a bubble. A completion that arrives in the same cycle as the waiting read releases it at once. The forward select then points the operand at that pipeline's result bus instead of the register file. Each completion strobe also becomes a register-file write enable. Register 0 is wired to zero: it is never marked stale and never written.

Top module: `sb_interlock`

## Requirements
- R1: Reset clears every stale flag. While reset is low, `stall`, `issue_int` and `issue_fp` are all 0. After reset is released, a read of any register issues without stalling.
- R2: When an instruction with `dec_wr`=1 and a nonzero destination issues, its destination becomes stale. A following read of that register stalls for 2 cycles behind an integer producer and for 4 cycles behind a floating-point producer.
- R3: While `dec_valid`=1 and a nonzero source register is stale, and no completion for that register arrives in this cycle, `stall` is 1 and both issue outputs are 0.
- R4: A stale source whose producer completes in the current cycle does not stall. Its forward select is 2'b01 for the integer result and 2'b10 for the floating-point result. In every other case the forward select is 2'b00, which means the register file.
- R5: Once a completion has been accepted, the register's flag is clear. From the next cycle on, reads of that register issue with forward select 2'b00.
- R6: A completion strobe with a nonzero destination raises that pipeline's write enable in the same cycle, with the write address equal to the completion destination.
- R7: Register 0 is never marked stale. Reads of register 0 never stall, and a completion aimed at register 0 raises no write enable.
- R8: An instruction whose destination is already stale stalls, unless that register completes in the same cycle. A second writer to the same register therefore issues only once the first writer has finished.
- R9: When both pipelines complete in the same cycle, both write enables rise and both flags clear. A single instruction may read both results through forwarding in that cycle.
- R10: If an instruction that targets register X issues in the same cycle as X completes, X stays stale, because the set takes precedence over the clear.
- R11: An issuing instruction raises `issue_int` when `dec_pipe`=0 and `issue_fp` when `dec_pipe`=1. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_src_a | input | 5 | First source register index |
| dec_src_b | input | 5 | Second source register index |
| dec_dst | input | 5 | Destination register index |
| dec_wr | input | 1 | Instruction writes its destination |
| dec_pipe | input | 1 | Target pipeline: 0 integer, 1 floating point |
| int_done | input | 1 | Integer pipeline completes this cycle |
| int_done_dst | input | 5 | Destination of the integer completion |
| fp_done | input | 1 | Floating-point pipeline completes this cycle |
| fp_done_dst | input | 5 | Destination of the floating-point completion |
| stall | output | 1 | Hold decode, freeze fetch |
| issue_int | output | 1 | Instruction enters the integer pipeline |
| issue_fp | output | 1 | Instruction enters the floating-point pipeline |
| fwd_sel_a | output | 2 | Operand A source: 00 register file, 01 integer result, 10 floating-point result |
| fwd_sel_b | output | 2 | Operand B source, same encoding |
| rf_we_int | output | 1 | Register-file write enable from the integer pipeline |
| rf_wa_int | output | 5 | Write address for the integer result |
| rf_we_fp | output | 1 | Register-file write enable from the floating-point pipeline |
| rf_wa_fp | output | 5 | Write address for the floating-point result |

## Verification
The properties assume that completions reflect real outstanding work. A completion is reported only for an instruction that issued earlier, and it arrives exactly at the pipeline latency. They also assume that a stalled instruction is presented again unchanged, and that the two pipelines never report the same register at once. The stimulus meets these assumptions by construction. The bench generates every completion from its own delay lines, which are loaded only when it predicts an issue. It re-presents an instruction until that instruction issues. Because the block's destination interlock already prevents two writers to one register, the two pipelines cannot report the same register in one cycle.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_INT = 2'b01,
      FWD_FP  = 2'b10
   } fwd_sel_e;

   typedef enum logic {
      PIPE_INT = 1'b0,
      PIPE_FP  = 1'b1
   } pipe_e;
endpackage

// File: rtl/sbi_dst_decode.sv
// Turns a register index plus enable into a one-hot vector; the zero
// register is optionally cut out so it can never be flagged or written.
module sbi_dst_decode #(
   parameter int NREGS      = 32,
   parameter int AW         = $clog2(NREGS),
   parameter bit ZERO_FIXED = 1'b1
) (
   input  logic             en,
   input  logic [AW-1:0]    idx,
   output logic [NREGS-1:0] vec
);
   for (genvar i = 0; i < NREGS; i++) begin : g_bit
      if (i == 0 && ZERO_FIXED) begin : g_zero
         assign vec[i] = 1'b0;
      end else begin : g_live
         assign vec[i] = en && (idx == AW'(i));
      end
   end
endmodule

// File: rtl/sbi_stale_array.sv
// One flag per register; a set in the same cycle as a clear wins.
module sbi_stale_array #(
   parameter int NREGS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NREGS-1:0] set_vec,
   input  logic [NREGS-1:0] clr_int_vec,
   input  logic [NREGS-1:0] clr_fp_vec,
   output logic [NREGS-1:0] stale
);
   for (genvar i = 0; i < NREGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stale[i] <= 1'b0;
         end else if (set_vec[i]) begin
            stale[i] <= 1'b1;
         end else if (clr_int_vec[i] || clr_fp_vec[i]) begin
            stale[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sbi_operand_check.sv
// Per-operand lookup: is the source waiting, and if its producer is
// finishing right now, which result bus should feed it.
module sbi_operand_check
   import sbi_pkg::*;
#(
   parameter int NREGS = 32,
   parameter int AW    = $clog2(NREGS)
) (
   input  logic [AW-1:0]    idx,
   input  logic [NREGS-1:0] stale,
   input  logic [NREGS-1:0] clr_int_vec,
   input  logic [NREGS-1:0] clr_fp_vec,
   output logic             hazard,
   output logic [1:0]       fwd_sel
);
   logic waiting;
   logic int_hit;
   logic fp_hit;

   assign waiting = stale[idx];
   assign int_hit = clr_int_vec[idx];
   assign fp_hit  = clr_fp_vec[idx];

   assign hazard = waiting && !(int_hit || fp_hit);

   always_comb begin
      fwd_sel = FWD_RF;
      if (waiting) begin
         if (fp_hit) begin
            fwd_sel = FWD_FP;
         end else if (int_hit) begin
            fwd_sel = FWD_INT;
         end
      end
   end
endmodule

// File: rtl/sb_interlock.sv
module sb_interlock
   import sbi_pkg::*;
#(
   parameter int NREGS      = 32,
   parameter int AW         = $clog2(NREGS),
   parameter bit ZERO_FIXED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dec_valid,
   input  logic [AW-1:0] dec_src_a,
   input  logic [AW-1:0] dec_src_b,
   input  logic [AW-1:0] dec_dst,
   input  logic          dec_wr,
   input  logic          dec_pipe,
   input  logic          int_done,
   input  logic [AW-1:0] int_done_dst,
   input  logic          fp_done,
   input  logic [AW-1:0] fp_done_dst,
   output logic          stall,
   output logic          issue_int,
   output logic          issue_fp,
   output logic [1:0]    fwd_sel_a,
   output logic [1:0]    fwd_sel_b,
   output logic          rf_we_int,
   output logic [AW-1:0] rf_wa_int,
   output logic          rf_we_fp,
   output logic [AW-1:0] rf_wa_fp
);
   localparam int NOPS = 2;

   if (NREGS < 2 || (1 << AW) != NREGS) begin : g_bad_size
      $error("sb_interlock: NREGS must be a power of two, at least 2, matching AW");
   end

   logic [NREGS-1:0]          stale;
   logic [NREGS-1:0]          set_vec;
   logic [NREGS-1:0]          clr_int_vec;
   logic [NREGS-1:0]          clr_fp_vec;
   logic [AW-1:0]             src_idx [NOPS];
   logic [NOPS-1:0]           src_hz;
   logic [NOPS-1:0][1:0]      src_fwd;
   logic                      dst_busy;
   logic                      blocked;
   logic                      go;

   assign src_idx[0] = dec_src_a;
   assign src_idx[1] = dec_src_b;

   sbi_dst_decode #(.NREGS(NREGS), .AW(AW), .ZERO_FIXED(ZERO_FIXED)) u_clr_int (
      .en (int_done),
      .idx(int_done_dst),
      .vec(clr_int_vec)
   );

   sbi_dst_decode #(.NREGS(NREGS), .AW(AW), .ZERO_FIXED(ZERO_FIXED)) u_clr_fp (
      .en (fp_done),
      .idx(fp_done_dst),
      .vec(clr_fp_vec)
   );

   for (genvar op = 0; op < NOPS; op++) begin : g_src
      sbi_operand_check #(.NREGS(NREGS), .AW(AW)) u_chk (
         .idx        (src_idx[op]),
         .stale      (stale),
         .clr_int_vec(clr_int_vec),
         .clr_fp_vec (clr_fp_vec),
         .hazard     (src_hz[op]),
         .fwd_sel    (src_fwd[op])
      );
   end

   // Output-ordering hold: a second writer waits for the first.
   assign dst_busy = stale[dec_dst] && !(clr_int_vec[dec_dst] || clr_fp_vec[dec_dst]);
   assign blocked  = (|src_hz) || (dec_wr && dst_busy);

   assign stall = rst_n && dec_valid && blocked;
   assign go    = rst_n && dec_valid && !blocked;

   assign issue_int = go && (pipe_e'(dec_pipe) == PIPE_INT);
   assign issue_fp  = go && (pipe_e'(dec_pipe) == PIPE_FP);

   assign fwd_sel_a = src_fwd[0];
   assign fwd_sel_b = src_fwd[1];

   sbi_dst_decode #(.NREGS(NREGS), .AW(AW), .ZERO_FIXED(ZERO_FIXED)) u_set (
      .en (go && dec_wr),
      .idx(dec_dst),
      .vec(set_vec)
   );

   sbi_stale_array #(.NREGS(NREGS)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_vec    (set_vec),
      .clr_int_vec(clr_int_vec),
      .clr_fp_vec (clr_fp_vec),
      .stale      (stale)
   );

   // Write enables come from the decoded clears so the zero-register
   // variant chosen above also governs register-file writes.
   assign rf_we_int = |clr_int_vec;
   assign rf_wa_int = int_done_dst;
   assign rf_we_fp  = |clr_fp_vec;
   assign rf_wa_fp  = fp_done_dst;
endmodule

// File: rtl/sbi_checker.sv
module sbi_checker #(
   parameter int AW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dec_valid,
   input logic [AW-1:0] dec_src_a,
   input logic [AW-1:0] dec_src_b,
   input logic [AW-1:0] dec_dst,
   input logic          dec_wr,
   input logic          int_done,
   input logic [AW-1:0] int_done_dst,
   input logic          fp_done,
   input logic [AW-1:0] fp_done_dst,
   input logic          stall,
   input logic          issue_int,
   input logic          issue_fp,
   input logic [1:0]    fwd_sel_a,
   input logic [1:0]    fwd_sel_b,
   input logic          rf_we_int,
   input logic [AW-1:0] rf_wa_int,
   input logic          rf_we_fp,
   input logic [AW-1:0] rf_wa_fp
);
   // R11
   one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({issue_int, issue_fp}));

   // R3
   stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (!issue_int && !issue_fp));

   // R2
   raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(issue_int || issue_fp) && $past(dec_wr) && ($past(dec_dst) != '0)
       && dec_valid && (dec_src_a == $past(dec_dst)) && !int_done && !fp_done)
      |-> stall);

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(issue_int || issue_fp) && $past(dec_wr) && ($past(dec_dst) != '0)
       && $past(int_done) && ($past(int_done_dst) == $past(dec_dst))
       && dec_valid && (dec_src_b == $past(dec_dst)) && !int_done && !fp_done)
      |-> stall);

   // R4
   fwd_int_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_sel_a == 2'b01) |-> (int_done && (int_done_dst == dec_src_a)));

   // R4
   fwd_fp_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_sel_b == 2'b10) |-> (fp_done && (fp_done_dst == dec_src_b)));

   // R7
   no_zero_int_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_int |-> (rf_wa_int != '0));

   // R7
   no_zero_fp_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_fp |-> (rf_wa_fp != '0));
endmodule

bind sb_interlock sbi_checker #(.AW(AW)) u_sbi_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .dec_valid   (dec_valid),
   .dec_src_a   (dec_src_a),
   .dec_src_b   (dec_src_b),
   .dec_dst     (dec_dst),
   .dec_wr      (dec_wr),
   .int_done    (int_done),
   .int_done_dst(int_done_dst),
   .fp_done     (fp_done),
   .fp_done_dst (fp_done_dst),
   .stall       (stall),
   .issue_int   (issue_int),
   .issue_fp    (issue_fp),
   .fwd_sel_a   (fwd_sel_a),
   .fwd_sel_b   (fwd_sel_b),
   .rf_we_int   (rf_we_int),
   .rf_wa_int   (rf_wa_int),
   .rf_we_fp    (rf_we_fp),
   .rf_wa_fp    (rf_wa_fp)
);

// File: tb/test_sb_interlock.sv
module test_sb_interlock;
   localparam int NR  = 32;
   localparam int AW  = 5;
   localparam int FPL = 5;
   localparam int INL = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dec_valid = 1'b0;
   logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
   logic          dec_wr = 1'b0, dec_pipe = 1'b0;
   logic          int_done = 1'b0, fp_done = 1'b0;
   logic [AW-1:0] int_done_dst = '0, fp_done_dst = '0;
   logic          stall, issue_int, issue_fp, rf_we_int, rf_we_fp;
   logic [1:0]    fwd_sel_a, fwd_sel_b;
   logic [AW-1:0] rf_wa_int, rf_wa_fp;

   int n_cmp = 0;
   int n_bad = 0;
   bit done_flag = 0;

   logic          bst [NR];
   logic          fq_v [FPL];
   logic [AW-1:0] fq_d [FPL];
   logic          iq_v [INL];
   logic [AW-1:0] iq_d [INL];

   bit       last_issue, last_stall;
   int       last_fwd_a, last_fwd_b;

   always #5 clk = ~clk;

   sb_interlock i_sb_interlock (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
      .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
      .dec_wr(dec_wr), .dec_pipe(dec_pipe),
      .int_done(int_done), .int_done_dst(int_done_dst),
      .fp_done(fp_done), .fp_done_dst(fp_done_dst),
      .stall(stall), .issue_int(issue_int), .issue_fp(issue_fp),
      .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
      .rf_we_int(rf_we_int), .rf_wa_int(rf_wa_int),
      .rf_we_fp(rf_we_fp), .rf_wa_fp(rf_wa_fp)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      for (int r = 0; r < NR; r++) bst[r] = 1'b0;
      for (int i = 0; i < FPL; i++) begin fq_v[i] = 1'b0; fq_d[i] = '0; end
      for (int i = 0; i < INL; i++) begin iq_v[i] = 1'b0; iq_d[i] = '0; end
   endtask

   // One clock: drive at the falling edge, compare 1 ns later, update the
   // reference model after the rising edge.
   task automatic cyc(input bit v, input logic [AW-1:0] a, input logic [AW-1:0] b,
                      input logic [AW-1:0] d, input bit w, input bit p);
      logic [NR-1:0] ci, cf;
      bit hza, hzb, waw, es, eii, eif, both;
      int fa, fb;
      @(negedge clk);
      dec_valid = v; dec_src_a = a; dec_src_b = b; dec_dst = d;
      dec_wr = w; dec_pipe = p;
      int_done = iq_v[0]; int_done_dst = iq_d[0];
      fp_done  = fq_v[0]; fp_done_dst  = fq_d[0];
      #1;
      ci = '0; cf = '0;
      if (iq_v[0] && iq_d[0] != 0) ci[iq_d[0]] = 1'b1;
      if (fq_v[0] && fq_d[0] != 0) cf[fq_d[0]] = 1'b1;
      hza = (a != 0) && bst[a] && !ci[a] && !cf[a];
      hzb = (b != 0) && bst[b] && !ci[b] && !cf[b];
      waw = w && (d != 0) && bst[d] && !ci[d] && !cf[d];
      es  = v && (hza || hzb || waw);
      eii = v && !es && !p;
      eif = v && !es && p;
      fa = ((a != 0) && bst[a]) ? (cf[a] ? 2 : (ci[a] ? 1 : 0)) : 0;
      fb = ((b != 0) && bst[b]) ? (cf[b] ? 2 : (ci[b] ? 1 : 0)) : 0;
      both = (ci != '0) && (cf != '0);
      chk(waw ? "R8 stall" : "R3 stall", int'(stall), int'(es));
      chk("R11 issue_int", int'(issue_int), int'(eii));
      chk("R11 issue_fp", int'(issue_fp), int'(eif));
      chk("R4 fwd_sel_a", int'(fwd_sel_a), fa);
      chk("R4 fwd_sel_b", int'(fwd_sel_b), fb);
      chk(both ? "R9 rf_we_int" : "R6 rf_we_int", int'(rf_we_int), int'(ci != '0));
      chk(both ? "R9 rf_we_fp" : "R6 rf_we_fp", int'(rf_we_fp), int'(cf != '0));
      if (ci != '0) chk("R6 rf_wa_int", int'(rf_wa_int), int'(iq_d[0]));
      if (cf != '0) chk("R6 rf_wa_fp", int'(rf_wa_fp), int'(fq_d[0]));
      last_issue = eii || eif;
      last_stall = stall;
      last_fwd_a = int'(fwd_sel_a);
      last_fwd_b = int'(fwd_sel_b);
      @(posedge clk);
      for (int r = 0; r < NR; r++) if (ci[r] || cf[r]) bst[r] = 1'b0;
      if (last_issue && w && d != 0) bst[d] = 1'b1;
      for (int i = 0; i < FPL - 1; i++) begin fq_v[i] = fq_v[i+1]; fq_d[i] = fq_d[i+1]; end
      fq_v[FPL-1] = eif && w; fq_d[FPL-1] = d;
      for (int i = 0; i < INL - 1; i++) begin iq_v[i] = iq_v[i+1]; iq_d[i] = iq_d[i+1]; end
      iq_v[INL-1] = eii && w; iq_d[INL-1] = d;
   endtask

   task automatic idle();
      cyc(1'b0, '0, '0, '0, 1'b0, 1'b0);
   endtask

   // Presents an instruction until it issues; returns stalled cycles.
   task automatic issue_one(input logic [AW-1:0] a, input logic [AW-1:0] b,
                            input logic [AW-1:0] d, input bit w, input bit p,
                            output int stalls);
      int n = 0;
      do begin
         cyc(1'b1, a, b, d, w, p);
         n++;
      end while (!last_issue && n < 40);
      stalls = n - 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int st;
      model_clear();
      // R1: outputs quiet in reset even with a request present
      dec_valid = 1'b1; dec_src_a = 5'd3; dec_src_b = 5'd4; dec_wr = 1'b1; dec_dst = 5'd5;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 stall in reset", int'(stall), 0);
      chk("R1 issue in reset", int'(issue_int || issue_fp), 0);
      dec_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every register readable right after reset
      for (int r = 0; r < NR; r++) begin
         cyc(1'b1, AW'(r), AW'(NR - 1 - r), '0, 1'b0, 1'b0);
         chk("R1 no stall after reset", int'(last_stall), 0);
      end

      // R2 / R4 / R5: sweep every register through both pipelines
      for (int r = 1; r < NR; r++) begin
         bit p = r[0];
         issue_one('0, '0, AW'(r), 1'b1, p, st);
         if (p) issue_one('0, AW'(r), '0, 1'b0, 1'b0, st);
         else   issue_one(AW'(r), '0, '0, 1'b0, 1'b0, st);
         chk("R2 stall cycles", st, p ? FPL - 1 : INL - 1);
         chk("R4 forward on release", p ? last_fwd_b : last_fwd_a, p ? 2 : 1);
         cyc(1'b1, AW'(r), AW'(r), '0, 1'b0, 1'b0);
         chk("R5 clear after completion", int'(last_stall), 0);
         chk("R5 reads register file", last_fwd_a, 0);
      end

      // R7: zero register never goes stale
      issue_one('0, '0, '0, 1'b1, 1'b1, st);
      issue_one('0, '0, '0, 1'b0, 1'b0, st);
      chk("R7 zero read never stalls", st, 0);
      repeat (6) idle();

      // R8: second writer waits for the first
      issue_one('0, '0, 5'd4, 1'b1, 1'b1, st);
      issue_one('0, '0, 5'd4, 1'b1, 1'b0, st);
      chk("R8 waw stall cycles", st, FPL - 1);
      repeat (6) idle();

      // R9: both pipelines finish together, one reader takes both
      issue_one('0, '0, 5'd5, 1'b1, 1'b1, st);
      idle();
      issue_one('0, '0, 5'd6, 1'b1, 1'b0, st);
      idle(); idle();
      issue_one(5'd5, 5'd6, '0, 1'b0, 1'b0, st);
      chk("R9 dual completion no stall", st, 0);
      chk("R9 fwd a from fp", last_fwd_a, 2);
      chk("R9 fwd b from int", last_fwd_b, 1);
      repeat (6) idle();

      // R10: set beats clear on the same register
      issue_one('0, '0, 5'd7, 1'b1, 1'b0, st);
      idle(); idle();
      issue_one('0, '0, 5'd7, 1'b1, 1'b1, st);
      chk("R10 writer issues on completion cycle", st, 0);
      issue_one('0, 5'd7, '0, 1'b0, 1'b0, st);
      chk("R10 register stays stale", st, FPL - 1);
      repeat (6) idle();

      // R1: reset mid-flight wipes a pending flag
      issue_one('0, '0, 5'd3, 1'b1, 1'b1, st);
      @(negedge clk);
      rst_n = 1'b0; dec_valid = 1'b0; int_done = 1'b0; fp_done = 1'b0;
      model_clear();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      issue_one(5'd3, '0, '0, 1'b0, 1'b0, st);
      chk("R1 reset clears flags", st, 0);

      // Mixed stream over a small register window (R2 R3 R4 R6 R8 R11)
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] rv = $urandom;
         if (rv[0] && rv[1]) idle();
         else issue_one(AW'(rv[4:2]), AW'(rv[7:5]), AW'(rv[10:8]), rv[11], rv[12], st);
      end
      repeat (6) idle();

      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule